// File: doc/BRIEF.md
# Window-Erasable Byte ROM Model

This block is a synthesizable behavioural model of a byte-wide read-only store that can be written and wiped in bulk. Reads are combinational. When the chip and output enables are both high, the addressed word appears on the data output in the same cycle. A program strobe can only clear bits. Every bit starts at 1. The only way to bring a cleared bit back to 1 is an erase, and an erase restores the whole array at once.

An identification input stands in for raising an address line to a high voltage. While it is high, the output shows one of two fixed code bytes, and the program and erase strobes are ignored. A saturating counter counts erases. Once the configured endurance is used up, a wear-out flag is raised. A program request that would need any cleared bit to return to 1 is refused: the stored word is left unchanged and a sticky error flag is set.

Top module: `uv_rom_model`

## Requirements
- R1: With chipEn and outEn high and idMode low, dataOut equals the word stored at addr in the same cycle. If either enable is low, dataOut is all zeros.
- R2: At a clock edge with chipEn and progReq high, and idMode and eraseReq low, the word at addr becomes old AND progData. This happens only when progData has no 1 in a bit position where the stored word holds a 0. A stored bit never changes from 0 to 1 except through an erase.
- R3: At a clock edge with chipEn and eraseReq high and idMode low, every word becomes all ones.
- R4: With chipEn, outEn and idMode high, dataOut is MFR_CODE when addr bit 0 is 0, and DEV_CODE when addr bit 0 is 1.
- R5: A program request that asks for a 1 where the stored bit is 0 leaves the word unchanged and sets progError. progError then stays high until reset.
- R6: wornOut goes high on the erase that brings the erase count to ERASE_LIMIT. Later erases still take effect, and wornOut stays high until reset.
- R7: While idMode is high, progReq and eraseReq have no effect on the stored data, the error flag or the wear count.
- R8: When eraseReq and progReq arrive at the same edge, only the erase takes effect. The result is all ones and no error is raised.
- R9: After reset, every word reads all ones and progError and wornOut are low.
- R10: Reads never advance the wear count. Any number of reads between erases leaves wornOut unchanged.
- R11: With chipEn low, progReq and eraseReq are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; loads a fresh array |
| chipEn | input | 1 | Chip select; gates reads and all strobes |
| outEn | input | 1 | Output enable for reads |
| addr | input | ADDR_W | Word address; bit 0 also picks the code byte |
| idMode | input | 1 | Identification request; shows code bytes and blocks strobes |
| progReq | input | 1 | Byte program strobe |
| progData | input | DATA_W | Data for a program request |
| eraseReq | input | 1 | Whole-array erase strobe |
| dataOut | output | DATA_W | Read data, code byte, or zero when disabled |
| progError | output | 1 | Sticky flag for a refused program request |
| wornOut | output | 1 | Sticky flag for erase endurance used up |

## Verification
The assertions assume rstN is held low through the first clock edge. They also assume that inputs change only away from the rising edge, so that a value sampled at one edge is the value the design acted on. The bit-monotonic check compares two consecutive reads of the same address, and it only applies when the earlier cycle carried no erase. The stimulus keeps to this by driving every input on the falling edge and by raising each strobe for exactly one cycle. Reads happen between strobes, with the enables held steady.

// File: rtl/uvRomPkg.sv
package uvRomPkg;
  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic wrWord;   // commit old AND progData at addr
    logic wipeAll;  // set every word to all ones
  } romStrobe_t;
endpackage

// File: rtl/uvRomDatapath.sv
module uvRomDatapath
  import uvRomPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h5A,
  parameter logic [DATA_W-1:0] DEV_CODE = 'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] progData,
  input  logic              idMode,
  input  logic              readEn,
  input  romStrobe_t        strobe,
  output logic [DATA_W-1:0] curWord,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // One register per word; a word is rewritten only when selected or wiped.
  for (genvar i = 0; i < DEPTH; i++) begin : gWord
    logic hit;
    assign hit = strobe.wrWord && (addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN || strobe.wipeAll) cells[i] <= '1;
      else if (hit)                cells[i] <= cells[i] & progData;
    end
  end

  assign curWord = cells[addr];

  always_comb begin
    if (!readEn)     dataOut = '0;
    else if (idMode) dataOut = addr[0] ? DEV_CODE : MFR_CODE;
    else             dataOut = curWord;
  end
endmodule

// File: rtl/uvRomControl.sv
module uvRomControl
  import uvRomPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERASE_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              idMode,
  input  logic              progReq,
  input  logic              eraseReq,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] curWord,
  output romStrobe_t        strobe,
  output logic              progError,
  output logic              wornOut
);
  localparam int CNT_W = $clog2(ERASE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERASE_LIMIT);

  logic [CNT_W-1:0] eraseCnt;
  logic accept, doErase, tryProg, needsSet;

  assign accept   = chipEn && !idMode;
  assign doErase  = accept && eraseReq;
  assign tryProg  = accept && progReq && !eraseReq;
  assign needsSet = |(progData & ~curWord);

  always_comb begin
    strobe.wipeAll = doErase;
    strobe.wrWord  = tryProg && !needsSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseCnt  <= '0;
      progError <= 1'b0;
      wornOut   <= 1'b0;
    end else begin
      if (tryProg && needsSet) progError <= 1'b1;
      if (doErase) begin
        if (eraseCnt != LIMIT) eraseCnt <= eraseCnt + 1'b1;
        if (eraseCnt + 1'b1 >= LIMIT) wornOut <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uv_rom_model.sv
module uv_rom_model
  import uvRomPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ERASE_LIMIT = 4,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h5A,
  parameter logic [DATA_W-1:0] DEV_CODE = 'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              outEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              idMode,
  input  logic              progReq,
  input  logic [DATA_W-1:0] progData,
  input  logic              eraseReq,
  output logic [DATA_W-1:0] dataOut,
  output logic              progError,
  output logic              wornOut
);
  romStrobe_t        strobe;
  logic [DATA_W-1:0] curWord;

  uvRomControl #(.DATA_W(DATA_W), .ERASE_LIMIT(ERASE_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .idMode(idMode),
    .progReq(progReq), .eraseReq(eraseReq), .progData(progData),
    .curWord(curWord), .strobe(strobe), .progError(progError),
    .wornOut(wornOut)
  );

  uvRomDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) uData (
    .clk(clk), .rstN(rstN), .addr(addr), .progData(progData),
    .idMode(idMode), .readEn(chipEn && outEn), .strobe(strobe),
    .curWord(curWord), .dataOut(dataOut)
  );
endmodule

// File: rtl/uvRomChecker.sv
module uvRomChecker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h5A,
  parameter logic [DATA_W-1:0] DEV_CODE = 'hC3
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEn,
  input logic              outEn,
  input logic [ADDR_W-1:0] addr,
  input logic              idMode,
  input logic              eraseReq,
  input logic [DATA_W-1:0] dataOut,
  input logic              progError,
  input logic              wornOut
);
  logic plainRead;
  assign plainRead = chipEn && outEn && !idMode;

  a_r1_disabled_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(chipEn && outEn) |-> dataOut == '0);

  a_r4_id_bytes: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && outEn && idMode) |-> dataOut == (addr[0] ? DEV_CODE : MFR_CODE));

  a_r3_erase_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && eraseReq && !idMode) |=> (!plainRead || dataOut == '1));

  a_r2_no_bit_rise: assert property (@(posedge clk) disable iff (!rstN)
    (plainRead && !eraseReq) |=>
      (!(plainRead && $stable(addr)) || ((dataOut & ~$past(dataOut)) == '0)));

  a_r5_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    progError |=> progError);

  a_r6_wear_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wornOut |=> wornOut);
endmodule

bind uv_rom_model uvRomChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) uChk (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .outEn(outEn), .addr(addr),
  .idMode(idMode), .eraseReq(eraseReq), .dataOut(dataOut),
  .progError(progError), .wornOut(wornOut)
);

// File: tb/tb_uv_rom_model.sv
module tb_uv_rom_model;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int LIMIT  = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b0, outEn = 1'b0, idMode = 1'b0;
  logic progReq = 1'b0, eraseReq = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] progData = '0;
  logic [DATA_W-1:0] dataOut;
  logic progError, wornOut;
  int nChecks = 0, nFails = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  uv_rom_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_LIMIT(LIMIT),
                 .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .outEn(outEn), .addr(addr),
    .idMode(idMode), .progReq(progReq), .progData(progData),
    .eraseReq(eraseReq), .dataOut(dataOut), .progError(progError),
    .wornOut(wornOut)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ 8'h96);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read one word at a falling edge, sample a little later.
  task automatic readAt(int a, logic [7:0] exp, string req);
    @(negedge clk);
    chipEn = 1'b1; outEn = 1'b1; idMode = 1'b0; addr = ADDR_W'(a);
    #1 check(req, dataOut, exp);
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < DEPTH; a++) readAt(a, model[a], req);
  endtask

  // One-cycle strobe; the edge between the two falling edges commits it.
  task automatic pulse(logic ce, logic id, logic pr, logic er, int a, logic [7:0] d);
    @(negedge clk);
    chipEn = ce; idMode = id; progReq = pr; eraseReq = er;
    addr = ADDR_W'(a); progData = d;
    @(negedge clk);
    progReq = 1'b0; eraseReq = 1'b0; idMode = 1'b0; chipEn = 1'b1;
  endtask

  task automatic modelErase();
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
  endtask

  initial begin
    #150000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    modelErase();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    check("R9 progError", progError, 0);
    check("R9 wornOut", wornOut, 0);
    sweep("R9 fresh array");

    // R1 output gating
    @(negedge clk); chipEn = 1'b1; outEn = 1'b0; #1 check("R1 outEn low", dataOut, 0);
    @(negedge clk); chipEn = 1'b0; outEn = 1'b1; #1 check("R1 chipEn low", dataOut, 0);

    // R4 identification bytes
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); chipEn = 1'b1; outEn = 1'b1; idMode = 1'b1; addr = ADDR_W'(a);
      #1 check("R4 id byte", dataOut, (a % 2) ? DEV : MFR);
    end
    idMode = 1'b0;

    // R2 program every word from the erased state, then a subset
    for (int a = 0; a < DEPTH; a++) begin
      pulse(1, 0, 1, 0, a, pat(a));
      model[a] = pat(a);
    end
    sweep("R2 first program");
    for (int a = 0; a < DEPTH; a++) begin
      pulse(1, 0, 1, 0, a, pat(a) & 8'hF0);
      model[a] = pat(a) & 8'hF0;
    end
    sweep("R2 cleared subset");
    check("R2 no error on legal program", progError, 0);

    // R11 strobes with chipEn low
    pulse(0, 0, 1, 0, 3, 8'h00);
    pulse(0, 0, 0, 1, 0, 8'h00);
    sweep("R11 chip disabled");
    check("R11 no wear from disabled erase", wornOut, 0);

    // R7 strobes during identification
    pulse(1, 1, 1, 0, 5, 8'h00);
    pulse(1, 1, 0, 1, 0, 8'h00);
    sweep("R7 id mode blocks strobes");
    check("R7 no error", progError, 0);

    // R5 refused program
    pulse(1, 0, 1, 0, 6, 8'h0F | model[6]);
    readAt(6, model[6], "R5 word unchanged");
    check("R5 error set", progError, 1);
    pulse(1, 0, 1, 0, 7, model[7]);
    check("R5 error sticky", progError, 1);

    // R3 erase #1; R8 erase beats program (#2)
    pulse(1, 0, 0, 1, 0, 8'h00);
    modelErase();
    sweep("R3 erase restores ones");
    pulse(1, 0, 1, 0, 2, 8'h12); model[2] = 8'h12;
    pulse(1, 0, 1, 1, 2, 8'h00); modelErase();
    readAt(2, 8'hFF, "R8 erase wins");

    // R10 many reads, then erase #3: still below limit
    for (int k = 0; k < 40; k++) readAt(k % DEPTH, 8'hFF, "R10 reads");
    pulse(1, 0, 0, 1, 0, 8'h00);
    check("R10 not worn after LIMIT-1 erases", wornOut, 0);

    // R6 erase #4 hits the limit, #5 still erases
    pulse(1, 0, 0, 1, 0, 8'h00);
    check("R6 worn at limit", wornOut, 1);
    pulse(1, 0, 1, 0, 9, 8'h3C); model[9] = 8'h3C;
    readAt(9, 8'h3C, "R6 program after wear");
    pulse(1, 0, 0, 1, 0, 8'h00); modelErase();
    readAt(9, 8'hFF, "R6 erase past limit");
    check("R6 flag stays", wornOut, 1);

    // R9 reset clears flags
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R9 flags cleared", {30'd0, progError, wornOut}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule